// File: doc/BRIEF.md
# Sub-Vector Swizzle Unit

This block reorders the components of a short sub-vector of up to four elements, named x, y, z and w. Every output lane picks its value from one of six sources: the constant zero, the constant one, or any of the four input components. The four lane choices do not sit in separate fixed-width fields. They arrive packed together as a single base-6 number in an 11-bit code, so the block first splits that code into four selector digits by repeated division by six.

The length of the sub-vector is from one to four lanes. It is supplied as length minus one. Lanes past the length produce zero. A component past the length also reads as zero. The result is captured in an output register and appears one cycle after the input is presented. The bit pattern used for the constant one is a parameter, so the same block serves integer and floating-point lanes.

Top module: `swz_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R2: The code is split as code = s0 + 6*s1 + 36*s2 + 216*s3. Output lane i (bits [i*COMP_W +: COMP_W] of `out_vec`) is driven by selector digit si.
- R3: Selector digit 0 makes the lane output all zeros.
- R4: Selector digit 1 makes the lane output the parameter `ONE_VAL`.
- R5: Selector digits 2, 3, 4 and 5 make the lane output input component 0, 1, 2 and 3 (x, y, z, w). Component k is taken from bits [k*COMP_W +: COMP_W] of `in_vec`.
- R6: A lane whose index is at or above the length (`in_len_m1`+1) outputs zero, whatever its digit holds.
- R7: A digit that names component k, where k is at or above the length, makes the lane output zero.
- R8: A code of 1296 or above sets `out_err` and makes the whole `out_vec` zero. A code below 1296 clears `out_err`.
- R9: While `in_valid` is low, `out_vec` and `out_err` keep their previous values.
- R10: After reset, `out_valid`, `out_err` and `out_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands are valid this cycle |
| in_code | input | 11 | Packed base-6 lane selectors |
| in_len_m1 | input | 2 | Sub-vector length minus one |
| in_vec | input | 4*COMP_W | Input components, x in the lowest slice |
| out_valid | output | 1 | Registered result is valid |
| out_err | output | 1 | Code was out of range |
| out_vec | output | 4*COMP_W | Swizzled output lanes, lane 0 in the lowest slice |

## Verification
The assertions assume that `in_valid`, `in_code` and `in_len_m1` are known values on every clock edge once reset is released. They also assume the inputs change only between edges. The stimulus drives every input on the falling edge and never leaves one undriven. It sweeps all 2048 code values against all four lengths, so it covers both valid and out-of-range codes. Each component carries a distinct nonzero pattern that differs from the constant one, so a wrong source choice always shows up as a wrong output value.

// File: rtl/swz_pkg.sv
package swz_pkg;
    localparam int LANES      = 4;
    localparam int RADIX      = 6;
    localparam int CODE_W     = 11;
    localparam int DIGIT_W    = 3;
    localparam int LEN_W      = 2;
    localparam int CODE_LIMIT = RADIX * RADIX * RADIX * RADIX;

    typedef enum logic [DIGIT_W-1:0] {
        SRC_ZERO = 3'd0,
        SRC_ONE  = 3'd1,
        SRC_X    = 3'd2,
        SRC_Y    = 3'd3,
        SRC_Z    = 3'd4,
        SRC_W    = 3'd5
    } src_sel_e;
endpackage

// File: rtl/swz_code_decoder.sv
module swz_code_decoder
    import swz_pkg::*;
(
    input  logic [CODE_W-1:0]              code,
    output logic [LANES-1:0][DIGIT_W-1:0]  digits,
    output logic                           code_ok
);
    localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CODE_LIMIT);
    localparam logic [CODE_W-1:0] BASE  = CODE_W'(RADIX);

    logic [CODE_W-1:0] rem_d;

    always_comb begin
        rem_d   = code;
        code_ok = (code < LIMIT);
        for (int i = 0; i < LANES; i++) begin
            digits[i] = DIGIT_W'(rem_d % BASE);
            rem_d     = rem_d / BASE;
        end
        if (!code_ok) begin
            digits = '0;
        end
    end

    always_comb begin
        if (code_ok) begin
            for (int i = 0; i < LANES; i++) begin
                assert (digits[i] < DIGIT_W'(RADIX)) else $error("digit out of range"); // R2
            end
        end
    end
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
    import swz_pkg::*;
#(
    parameter int                  COMP_W   = 64,
    parameter logic [COMP_W-1:0]   ONE_VAL  = COMP_W'(1),
    parameter int                  LANE_IDX = 0
) (
    input  logic [DIGIT_W-1:0]             sel,
    input  logic [LEN_W-1:0]               len_m1,
    input  logic [LANES-1:0][COMP_W-1:0]   comps,
    output logic [COMP_W-1:0]              lane_val
);
    logic       lane_active;
    logic [1:0] comp_idx;

    always_comb begin
        lane_active = (LANE_IDX <= int'(len_m1));
        comp_idx    = 2'(sel - DIGIT_W'(SRC_X));
        lane_val    = '0;
        if (lane_active) begin
            case (src_sel_e'(sel))
                SRC_ZERO: lane_val = '0;
                SRC_ONE:  lane_val = ONE_VAL;
                SRC_X, SRC_Y, SRC_Z, SRC_W: begin
                    if (comp_idx <= len_m1) begin
                        lane_val = comps[comp_idx];
                    end
                end
                default:  lane_val = '0;
            endcase
        end
    end
endmodule

// File: rtl/swz_unit.sv
module swz_unit
    import swz_pkg::*;
#(
    parameter int                COMP_W  = 64,
    parameter logic [COMP_W-1:0] ONE_VAL = COMP_W'(1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [CODE_W-1:0]          in_code,
    input  logic [LEN_W-1:0]           in_len_m1,
    input  logic [LANES*COMP_W-1:0]    in_vec,
    output logic                       out_valid,
    output logic                       out_err,
    output logic [LANES*COMP_W-1:0]    out_vec
);
    localparam int VEC_W = LANES * COMP_W;

    typedef struct packed {
        logic               valid;
        logic               err;
        logic [VEC_W-1:0]   vec;
    } out_state_t;

    out_state_t                       st_d, st_q;
    logic [LANES-1:0][COMP_W-1:0]     comps;
    logic [LANES-1:0][COMP_W-1:0]     lane_vals;
    logic [LANES-1:0][DIGIT_W-1:0]    digits;
    logic                             code_ok;

    assign comps = in_vec;

    swz_code_decoder u_dec (
        .code    (in_code),
        .digits  (digits),
        .code_ok (code_ok)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swz_lane_mux #(
            .COMP_W   (COMP_W),
            .ONE_VAL  (ONE_VAL),
            .LANE_IDX (g)
        ) u_mux (
            .sel      (digits[g]),
            .len_m1   (in_len_m1),
            .comps    (comps),
            .lane_val (lane_vals[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.err = !code_ok;
            st_d.vec = code_ok ? lane_vals : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_err   = st_q.err;
    assign out_vec   = st_q.vec;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_BAD_CODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code >= CODE_W'(CODE_LIMIT)) |=> (out_err && out_vec == '0)); // R8
    AST_GOOD_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code < CODE_W'(CODE_LIMIT)) |=> !out_err); // R8
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_len_m1 == '0) |=> (out_vec[VEC_W-1:COMP_W] == '0)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_err))); // R9
endmodule

// File: tb/swz_unit_tb_top.sv
module swz_unit_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 8;
    localparam logic [W-1:0] ONE_PAT   = 8'hA5;
    localparam int          WATCHDOG   = 200000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [10:0]      in_code;
    logic [1:0]       in_len_m1;
    logic [4*W-1:0]   in_vec;
    logic             out_valid;
    logic             out_err;
    logic [4*W-1:0]   out_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swz_unit #(.COMP_W(W), .ONE_VAL(ONE_PAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .in_len_m1 (in_len_m1),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_err   (out_err),
        .out_vec   (out_vec)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (code %0d len %0d)",
                     req, act, exp, in_code, in_len_m1 + 1);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [4*W-1:0] last_vec;
        logic           last_err;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_code   = '0;
        in_len_m1 = '0;
        in_vec    = '0;
        repeat (3) @(negedge clk);
        check("R10 valid", 64'(out_valid), 64'd0);
        check("R10 err",   64'(out_err),   64'd0);
        check("R10 vec",   64'(out_vec),   64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int code = 0; code < 2048; code++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int k = 0; k < 4; k++) begin
                    in_vec[k*W +: W] = {4'(k + 1), 4'(code)};
                end
                in_code   = 11'(code);
                in_len_m1 = 2'(len - 1);
                in_valid  = 1'b1;
                @(negedge clk);
                check("R1 valid", 64'(out_valid), 64'd1);
                if (code >= 1296) begin
                    check("R8 err", 64'(out_err), 64'd1);
                    check("R8 vec", 64'(out_vec), 64'd0);
                end else begin
                    check("R8 err clear", 64'(out_err), 64'd0);
                    for (int lane = 0; lane < 4; lane++) begin
                        int div;
                        int dig;
                        logic [W-1:0] exp;
                        string tag;
                        div = (lane == 0) ? 1 : (lane == 1) ? 6 : (lane == 2) ? 36 : 216;
                        dig = (code / div) % 6;
                        if (lane >= len) begin
                            exp = '0; tag = "R6 lane beyond length";
                        end else if (dig == 0) begin
                            exp = '0; tag = "R3 zero (R2 digit)";
                        end else if (dig == 1) begin
                            exp = ONE_PAT; tag = "R4 one (R2 digit)";
                        end else if (dig - 2 >= len) begin
                            exp = '0; tag = "R7 component beyond length";
                        end else begin
                            exp = {4'(dig - 1), 4'(code)}; tag = "R5 component (R2 digit)";
                        end
                        check(tag, 64'(out_vec[lane*W +: W]), 64'(exp));
                    end
                end
            end
        end

        last_vec  = out_vec;
        last_err  = out_err;
        in_valid  = 1'b0;
        in_code   = 11'd2;
        in_len_m1 = 2'd3;
        in_vec    = {4{8'h77}};
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        check("R9 hold vec",   64'(out_vec),   64'(last_vec));
        check("R9 hold err",   64'(out_err),   64'(last_err));
        in_code = 11'd1500;
        @(negedge clk);
        check("R9 hold err bad code", 64'(out_err), 64'(last_err));
        check("R9 hold vec bad code", 64'(out_vec), 64'(last_vec));
        report();
    end
endmodule